// File: doc/BRIEF.md
# Flash Buffer Page DMA Engine

A single-channel copy engine that moves one page between the buffer RAM of a flash controller and system memory. Software programs a source address, a destination address, a separate configuration word for each side (burst length, fixed or incrementing address, beat width), a byte count and a transfer direction. It then writes a start bit to the command register. The engine reads a chunk of source beats into a small staging buffer and writes the same bytes out as destination beats. Because each side has its own width, the engine packs 8- and 16-bit beats into 32-bit beats, or splits 32-bit beats into narrower ones. All data is little-endian: the lowest byte address sits on the least significant lane.

The engine reaches memory through a request/grant master port. Each beat holds its request until it is granted. Read data and the error response come back in the cycle of the grant. A status word reports busy, done and error. Done and error stay set until software clears them through their own command bits. The direction setting is latched at start and presented as a level to the flash side.

Top module: `flash_buf_dma`

## Requirements
- R1: After reset the status word reads 0, no memory request is raised, and every programming register reads 0.
- R2: The registers sit at byte offsets 0x400 (source address), 0x404 (source config), 0x408 (destination address), 0x40C (destination config), 0x414 (byte count, 20 bits), 0x418 (command, reads 0), 0x41C (status) and 0x420 (direction, bit 0). A config word keeps only burst code bits 18:16, fixed-address bit 8 and width code bits 1:0, and reads 0 in every other bit.
- R3: Writing 1 to command bit 0 while idle starts a transfer. Status bit 17 (busy) reads 1 from the next cycle, and the engine alternates between reading source beats and writing destination beats.
- R4: The destination receives exactly the source byte stream, for width codes 0 = 8-bit, 1 = 16-bit and 2 = 32-bit on either side. Narrow beats are packed little-endian into wider ones, and wider beats are unpacked the same way.
- R5: With config bit 8 at 0 a side's address advances by its beat width after each granted beat. With bit 8 at 1 it stays at the programmed address.
- R6: Burst codes 0, 2, 3 and 4 mean 1, 4, 8 and 16 beats. The last-beat flag marks the final beat of each burst, and the final burst of a side is shortened when fewer beats remain.
- R7: When the last destination beat is granted, busy falls and status bit 18 (done) rises in the same cycle. Done stays set until it is cleared. A byte count of 0 sets done at once and issues no beats.
- R8: An error response on a granted beat ends the transfer with no further requests and sets both error (status bit 16) and done. A byte count that is not a multiple of the wider beat width, a width code of 3, or a burst code of 1, 5, 6 or 7 does the same without issuing any beat.
- R9: Command bit 16 clears error. Command bit 18 clears done only while error is already clear, so a single write carrying both bits clears error and leaves done set.
- R10: A start command while busy is ignored, and register writes during a transfer do not change the running transfer.
- R11: The direction output presents direction bit 0 as sampled at start (0 reads from the flash buffer, 1 writes to it) for the whole transfer.
- R12: A raised request keeps its address, beat width and write flag unchanged until it is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mem_req | output | 1 | Beat request |
| mem_we | output | 1 | 1 for a destination write beat, 0 for a source read beat |
| mem_addr | output | 32 | Beat byte address |
| mem_size | output | 2 | Beat width code (0 = 8, 1 = 16, 2 = 32 bit) |
| mem_last | output | 1 | Final beat of the current burst |
| mem_wdata | output | 32 | Write data, right-justified |
| mem_gnt | input | 1 | Beat accepted this cycle |
| mem_rdata | input | 32 | Read data, valid with the grant |
| mem_err | input | 1 | Error response, valid with the grant |
| flash_write | output | 1 | Latched transfer direction |

## Verification
A wrong chunk length or staging index shows as a wrong byte at the destination, and the compare after completion catches it. A wrong burst counter or address step shows on the very beat where it occurs, as an unexpected last flag or address, and a beat monitor compares each granted beat with a model of each side's sequence. Flag-handling faults show in the status word within one cycle of the event or command, and the bench reads the status word after every such event. A start that leaks through while busy shows as extra beats, or as a second run of beats after done.

// File: rtl/fdma_pkg.sv
// Shared encodings for the flash buffer page DMA engine.
// Assumes a 32-bit register word and a 32-bit memory data path.
package fdma_pkg;

    localparam logic [11:0] OFS_SRC_ADDR = 12'h400;
    localparam logic [11:0] OFS_SRC_CFG  = 12'h404;
    localparam logic [11:0] OFS_DST_ADDR = 12'h408;
    localparam logic [11:0] OFS_DST_CFG  = 12'h40C;
    localparam logic [11:0] OFS_SIZE     = 12'h414;
    localparam logic [11:0] OFS_CMD      = 12'h418;
    localparam logic [11:0] OFS_STATUS   = 12'h41C;
    localparam logic [11:0] OFS_DIR      = 12'h420;

    localparam int CMD_GO_BIT      = 0;
    localparam int CMD_ERR_CLR_BIT = 16;
    localparam int CMD_FIN_CLR_BIT = 18;

    localparam int MAX_BURST_BEATS = 16;
    localparam int LANE_BYTES      = 4;

    typedef struct packed {
        logic [2:0] burst;
        logic       fixed;
        logic [1:0] width;
    } side_cfg_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_FETCH = 2'd1,
        PH_STORE = 2'd2
    } phase_t;

    // Beats per burst for a burst code, 0 for an unused code.
    function automatic logic [4:0] beats_of(input logic [2:0] code);
        case (code)
            3'd0:    beats_of = 5'd1;
            3'd2:    beats_of = 5'd4;
            3'd3:    beats_of = 5'd8;
            3'd4:    beats_of = 5'd16;
            default: beats_of = 5'd0;
        endcase
    endfunction

    // A side configuration is usable when both codes are defined.
    function automatic logic side_ok(input side_cfg_t c);
        side_ok = (beats_of(c.burst) != 5'd0) && (c.width != 2'd3);
    endfunction

    // Register image of a side configuration.
    function automatic logic [31:0] cfg_word(input side_cfg_t c);
        cfg_word = {13'b0, c.burst, 7'b0, c.fixed, 6'b0, c.width};
    endfunction

endpackage

// File: rtl/fdma_regs.sv
// Register file and status flags of the DMA engine.
// Holds the programming registers, decodes command writes and keeps the
// done/error flags. Assumes the engine samples the programming outputs
// only in the cycle a start is accepted.
module fdma_regs
    import fdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [11:0]       reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              busy,
    input  logic              fin,
    input  logic              fin_err,
    output logic              go,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output side_cfg_t         src_cfg,
    output side_cfg_t         dst_cfg,
    output logic [SIZE_W-1:0] size,
    output logic              dir
);

    logic done_q, err_q;
    logic cmd_wr;

    assign cmd_wr = reg_wr && (reg_addr == OFS_CMD);
    assign go     = cmd_wr && reg_wdata[CMD_GO_BIT] && !busy;

    // Programming registers: plain stores, no effect on a running transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_addr <= '0;
            dst_addr <= '0;
            src_cfg  <= '0;
            dst_cfg  <= '0;
            size     <= '0;
            dir      <= 1'b0;
        end else if (reg_wr) begin
            case (reg_addr)
                OFS_SRC_ADDR: src_addr <= reg_wdata[ADDR_W-1:0];
                OFS_DST_ADDR: dst_addr <= reg_wdata[ADDR_W-1:0];
                OFS_SRC_CFG:  src_cfg  <= {reg_wdata[18:16], reg_wdata[8], reg_wdata[1:0]};
                OFS_DST_CFG:  dst_cfg  <= {reg_wdata[18:16], reg_wdata[8], reg_wdata[1:0]};
                OFS_SIZE:     size     <= reg_wdata[SIZE_W-1:0];
                OFS_DIR:      dir      <= reg_wdata[0];
                default: ;
            endcase
        end
    end

    // Done/error flags: start clears, commands clear in order, finish sets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (go) begin
                done_q <= 1'b0;
                err_q  <= 1'b0;
            end
            if (cmd_wr && reg_wdata[CMD_ERR_CLR_BIT]) err_q <= 1'b0;
            if (cmd_wr && reg_wdata[CMD_FIN_CLR_BIT] && !err_q) done_q <= 1'b0;
            if (fin)     done_q <= 1'b1;
            if (fin_err) err_q  <= 1'b1;
        end
    end

    // Read mux over the register offsets.
    always_comb begin
        case (reg_addr)
            OFS_SRC_ADDR: reg_rdata = 32'(src_addr);
            OFS_DST_ADDR: reg_rdata = 32'(dst_addr);
            OFS_SRC_CFG:  reg_rdata = cfg_word(src_cfg);
            OFS_DST_CFG:  reg_rdata = cfg_word(dst_cfg);
            OFS_SIZE:     reg_rdata = 32'(size);
            OFS_STATUS:   reg_rdata = {13'b0, done_q, busy, err_q, 16'b0};
            OFS_DIR:      reg_rdata = {31'b0, dir};
            default:      reg_rdata = 32'b0;
        endcase
    end

    // R8
    err_implies_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> done_q);

    // R7
    done_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_q && busy));

endmodule

// File: rtl/fdma_pack_buf.sv
// Byte-addressed staging buffer that packs and unpacks beats.
// A write stores the low 1, 2 or 4 lanes of a beat at a byte index; a read
// returns 1, 2 or 4 bytes from a byte index, right-justified. Assumes the
// index plus the beat width never passes the buffer end.
module fdma_pack_buf #(
    parameter int BYTES = 64,
    parameter int LANES = 4
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [$clog2(BYTES)-1:0] wr_idx,
    input  logic [1:0]               wr_width,
    input  logic [8*LANES-1:0]       wr_data,
    input  logic [$clog2(BYTES)-1:0] rd_idx,
    input  logic [1:0]               rd_width,
    output logic [8*LANES-1:0]       rd_data
);

    localparam int IDX_W = $clog2(BYTES);

    logic [7:0] store_q [BYTES];
    logic [LANES-1:0] wr_lanes, rd_lanes;

    // Lane enables from a width code.
    function automatic logic [LANES-1:0] lanes_of(input logic [1:0] w);
        for (int b = 0; b < LANES; b++) lanes_of[b] = (b < (1 << w));
    endfunction

    assign wr_lanes = lanes_of(wr_width);
    assign rd_lanes = lanes_of(rd_width);

    // Data storage has no reset: every byte is written before it is read.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int b = 0; b < LANES; b++) begin
                if (wr_lanes[b]) store_q[IDX_W'(wr_idx + IDX_W'(b))] <= wr_data[8*b +: 8];
            end
        end
    end

    // Gather the enabled lanes of the outgoing beat.
    always_comb begin
        rd_data = '0;
        for (int b = 0; b < LANES; b++) begin
            if (rd_lanes[b]) rd_data[8*b +: 8] = store_q[IDX_W'(rd_idx + IDX_W'(b))];
        end
    end

endmodule

// File: rtl/fdma_engine.sv
// Transfer sequencer of the DMA engine.
// Samples the programming registers at start, checks them, then alternates
// a fetch phase (source beats into the staging buffer) and a store phase
// (buffer out as destination beats), one chunk at a time. A chunk is the
// larger of the two burst spans, cut to the bytes that remain. Assumes a
// grant completes a beat, with read data and error valid in that cycle.
module fdma_engine
    import fdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [ADDR_W-1:0] dst_addr,
    input  side_cfg_t         src_cfg,
    input  side_cfg_t         dst_cfg,
    input  logic [SIZE_W-1:0] size,
    input  logic              dir,
    output logic              busy,
    output logic              fin,
    output logic              fin_err,
    output logic              flash_write,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic              mem_last,
    output logic [31:0]       mem_wdata,
    input  logic              mem_gnt,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_err
);

    localparam int BUF_BYTES = MAX_BURST_BEATS * LANE_BYTES;
    localparam int CH_W      = $clog2(BUF_BYTES + 1);
    localparam int IDX_W     = $clog2(BUF_BYTES);
    localparam int BC_W      = $clog2(MAX_BURST_BEATS + 1);

    phase_t            ph_q;
    logic [SIZE_W-1:0] rem_q;
    logic [CH_W-1:0]   span_q, chunk_q, idx_q;
    logic [BC_W-1:0]   bcnt_q;
    logic [ADDR_W-1:0] src_q, dst_q;
    side_cfg_t         scfg_q, dcfg_q;
    logic              dir_q;

    side_cfg_t         cur;
    logic [CH_W-1:0]   wbytes, idx_nxt, s_span, d_span, span_in;
    logic [1:0]        wmax, wmask;
    logic              hs, beat_end, burst_end, cfg_ok, size_ok, launch_bad, launch_ok;
    logic [SIZE_W-1:0] rem_after;

    // Bytes of the next chunk: the remaining count capped by the span.
    function automatic logic [CH_W-1:0] chunk_of(input logic [SIZE_W-1:0] r,
                                                 input logic [CH_W-1:0] s);
        chunk_of = (r < SIZE_W'(s)) ? CH_W'(r) : s;
    endfunction

    // Start checks and span from the live programming registers.
    always_comb begin
        s_span     = CH_W'(beats_of(src_cfg.burst)) << src_cfg.width;
        d_span     = CH_W'(beats_of(dst_cfg.burst)) << dst_cfg.width;
        span_in    = (s_span > d_span) ? s_span : d_span;
        wmax       = (src_cfg.width > dst_cfg.width) ? src_cfg.width : dst_cfg.width;
        wmask      = 2'((3'd1 << wmax) - 3'd1);
        cfg_ok     = side_ok(src_cfg) && side_ok(dst_cfg);
        size_ok    = (size[1:0] & wmask) == 2'b00;
        launch_bad = go && (ph_q == PH_IDLE) && !(cfg_ok && size_ok);
        launch_ok  = go && (ph_q == PH_IDLE) && cfg_ok && size_ok && (size != '0);
    end

    // Beat-level decode for the active side.
    always_comb begin
        cur       = (ph_q == PH_STORE) ? dcfg_q : scfg_q;
        wbytes    = CH_W'(1) << cur.width;
        idx_nxt   = idx_q + wbytes;
        beat_end  = (idx_nxt == chunk_q);
        burst_end = (bcnt_q + BC_W'(1)) == BC_W'(beats_of(cur.burst));
        hs        = mem_req && mem_gnt;
        rem_after = rem_q - SIZE_W'(chunk_q);
    end

    assign busy        = (ph_q != PH_IDLE);
    assign mem_req     = busy;
    assign mem_we      = (ph_q == PH_STORE);
    assign mem_addr    = mem_we ? dst_q : src_q;
    assign mem_size    = cur.width;
    assign mem_last    = burst_end || beat_end;
    assign flash_write = dir_q;

    assign fin_err = launch_bad || (hs && mem_err);
    assign fin     = fin_err || (go && (ph_q == PH_IDLE) && size == '0)
                   || (hs && !mem_err && mem_we && beat_end && rem_after == '0);

    // Phase sequencing, counters and address stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q    <= PH_IDLE;
            rem_q   <= '0;
            span_q  <= '0;
            chunk_q <= '0;
            idx_q   <= '0;
            bcnt_q  <= '0;
            src_q   <= '0;
            dst_q   <= '0;
            scfg_q  <= '0;
            dcfg_q  <= '0;
            dir_q   <= 1'b0;
        end else begin
            case (ph_q)
                PH_IDLE: begin
                    if (launch_ok) begin
                        src_q   <= src_addr;
                        dst_q   <= dst_addr;
                        scfg_q  <= src_cfg;
                        dcfg_q  <= dst_cfg;
                        dir_q   <= dir;
                        rem_q   <= size;
                        span_q  <= span_in;
                        chunk_q <= chunk_of(size, span_in);
                        idx_q   <= '0;
                        bcnt_q  <= '0;
                        ph_q    <= PH_FETCH;
                    end
                end
                PH_FETCH: begin
                    if (hs) begin
                        if (mem_err) begin
                            ph_q <= PH_IDLE;
                        end else begin
                            if (!scfg_q.fixed) src_q <= src_q + ADDR_W'(wbytes);
                            bcnt_q <= burst_end ? '0 : bcnt_q + BC_W'(1);
                            idx_q  <= idx_nxt;
                            if (beat_end) begin
                                idx_q  <= '0;
                                bcnt_q <= '0;
                                ph_q   <= PH_STORE;
                            end
                        end
                    end
                end
                PH_STORE: begin
                    if (hs) begin
                        if (mem_err) begin
                            ph_q <= PH_IDLE;
                        end else begin
                            if (!dcfg_q.fixed) dst_q <= dst_q + ADDR_W'(wbytes);
                            bcnt_q <= burst_end ? '0 : bcnt_q + BC_W'(1);
                            idx_q  <= idx_nxt;
                            if (beat_end) begin
                                rem_q   <= rem_after;
                                idx_q   <= '0;
                                bcnt_q  <= '0;
                                chunk_q <= chunk_of(rem_after, span_q);
                                ph_q    <= (rem_after == '0) ? PH_IDLE : PH_FETCH;
                            end
                        end
                    end
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    fdma_pack_buf #(
        .BYTES (BUF_BYTES),
        .LANES (LANE_BYTES)
    ) i_stage (
        .clk      (clk),
        .wr_en    (hs && !mem_err && (ph_q == PH_FETCH)),
        .wr_idx   (idx_q[IDX_W-1:0]),
        .wr_width (scfg_q.width),
        .wr_data  (mem_rdata),
        .rd_idx   (idx_q[IDX_W-1:0]),
        .rd_width (dcfg_q.width),
        .rd_data  (mem_wdata)
    );

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_size)));

    // R6
    chunk_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (idx_q < chunk_q) && (chunk_q <= CH_W'(BUF_BYTES)));

    // R5
    src_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_FETCH && hs && !mem_err && scfg_q.fixed) |=> $stable(src_q));

endmodule

// File: rtl/flash_buf_dma.sv
// Top of the flash buffer page DMA engine: register file plus sequencer.
// Assumes a single register master and a memory slave that answers one beat
// per grant.
module flash_buf_dma
    import fdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [11:0]       reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic              mem_last,
    output logic [31:0]       mem_wdata,
    input  logic              mem_gnt,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_err,
    output logic              flash_write
);

    logic              go, busy, fin, fin_err, dir;
    logic [ADDR_W-1:0] src_addr, dst_addr;
    side_cfg_t         src_cfg, dst_cfg;
    logic [SIZE_W-1:0] size;

    fdma_regs #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy),
        .fin       (fin),
        .fin_err   (fin_err),
        .go        (go),
        .src_addr  (src_addr),
        .dst_addr  (dst_addr),
        .src_cfg   (src_cfg),
        .dst_cfg   (dst_cfg),
        .size      (size),
        .dir       (dir)
    );

    fdma_engine #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) i_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .go          (go),
        .src_addr    (src_addr),
        .dst_addr    (dst_addr),
        .src_cfg     (src_cfg),
        .dst_cfg     (dst_cfg),
        .size        (size),
        .dir         (dir),
        .busy        (busy),
        .fin         (fin),
        .fin_err     (fin_err),
        .flash_write (flash_write),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_size    (mem_size),
        .mem_last    (mem_last),
        .mem_wdata   (mem_wdata),
        .mem_gnt     (mem_gnt),
        .mem_rdata   (mem_rdata),
        .mem_err     (mem_err)
    );

endmodule

// File: tb/test_flash_buf_dma.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random transfers against a byte
// memory model and a per-beat sequence monitor.
module test_flash_buf_dma;

    localparam logic [11:0] A_SRC = 12'h400, A_SCFG = 12'h404, A_DST = 12'h408,
                            A_DCFG = 12'h40C, A_SIZE = 12'h414, A_CMD = 12'h418,
                            A_STAT = 12'h41C, A_DIR = 12'h420;
    localparam logic [31:0] ST_DONE = 32'h0004_0000, ST_BUSY = 32'h0002_0000,
                            ST_ERR = 32'h0001_0000;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        mem_req, mem_we, mem_last, mem_gnt = 1'b0, mem_err, flash_write;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [1:0]  mem_size;

    logic [7:0]  bmem [0:2047];
    logic [7:0]  ssnap [0:255];
    int          total = 0, fails = 0, cyc = 0, gnt_pct = 100;
    logic        err_en = 1'b0;
    logic [31:0] err_addr = '0;

    // transfer being monitored
    int          t_src, t_dst, t_sw, t_dw, t_sb, t_db, t_sz;
    bit          t_sfx, t_dfx;
    int          rd_n, wr_n, bad_n, hs_n;

    always #2.5 clk = ~clk;

    flash_buf_dma i_flash_buf_dma (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_last(mem_last), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
        .mem_rdata(mem_rdata), .mem_err(mem_err), .flash_write(flash_write)
    );

    logic [10:0] ma;
    assign ma        = mem_addr[10:0];
    assign mem_rdata = {bmem[ma + 11'd3], bmem[ma + 11'd2], bmem[ma + 11'd1], bmem[ma]};
    assign mem_err   = mem_gnt && err_en && (mem_addr == err_addr);

    function automatic int beats_n(input int code);
        case (code)
            0: return 1;
            2: return 4;
            3: return 8;
            default: return 16;
        endcase
    endfunction

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    // Responder grant, changed away from the active edge.
    always @(negedge clk) mem_gnt = mem_req && (($urandom % 100) < gnt_pct);

    // Memory writes and per-beat sequence monitor.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            total++; fails++;
            $display("FAIL watchdog: run did not finish");
            summary();
            $finish;
        end
        if (mem_req && mem_gnt) begin
            hs_n++;
            if (!mem_err) begin
                if (!mem_we) begin
                    if (mem_addr != 32'(t_sfx ? t_src : t_src + rd_n * (1 << t_sw)) ||
                        mem_size != 2'(t_sw) ||
                        mem_last != ((((rd_n + 1) % t_sb) == 0) || ((rd_n + 1) == (t_sz >> t_sw))))
                        bad_n++;
                    rd_n++;
                end else begin
                    if (mem_addr != 32'(t_dfx ? t_dst : t_dst + wr_n * (1 << t_dw)) ||
                        mem_size != 2'(t_dw) ||
                        mem_last != ((((wr_n + 1) % t_db) == 0) || ((wr_n + 1) == (t_sz >> t_dw))))
                        bad_n++;
                    for (int b = 0; b < (1 << mem_size); b++) bmem[ma + 11'(b)] = mem_wdata[8*b +: 8];
                    wr_n++;
                end
            end
        end
    end

    task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [11:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 4000; i++) begin
            rd_reg(A_STAT, v);
            if (!v[17]) break;
        end
    endtask

    // Programs one transfer and starts it; records it for the monitor.
    task automatic launch(input int s, input int d, input int swc, input int dwc,
                          input int sbc, input int dbc, input bit sfx, input bit dfx,
                          input int sz, input bit dirv);
        t_src = s; t_dst = d; t_sw = swc; t_dw = dwc; t_sb = beats_n(sbc);
        t_db = beats_n(dbc); t_sfx = sfx; t_dfx = dfx; t_sz = sz;
        rd_n = 0; wr_n = 0; bad_n = 0; hs_n = 0;
        for (int j = 0; j < 256; j++) begin
            ssnap[j] = bmem[11'(s + j)];
            bmem[11'(d + j)] = 8'($urandom);
        end
        wr_reg(A_SRC, 32'(s));
        wr_reg(A_DST, 32'(d));
        wr_reg(A_SCFG, 32'((sbc << 16) | (int'(sfx) << 8) | swc));
        wr_reg(A_DCFG, 32'((dbc << 16) | (int'(dfx) << 8) | dwc));
        wr_reg(A_SIZE, 32'(sz));
        wr_reg(A_DIR, {31'b0, dirv});
        wr_reg(A_CMD, 32'h1);
    endtask

    // Waits for the end of a good transfer and checks it.
    task automatic finish(input string tag);
        logic [31:0] v;
        int          mism, k;
        logic [7:0]  e;
        wait_idle();
        rd_reg(A_STAT, v);
        chk(v == ST_DONE, "R7", {tag, " status"}, v, ST_DONE);
        mism = 0;
        for (int j = 0; j < (t_dfx ? (1 << t_dw) : t_sz); j++) begin
            k = t_dfx ? t_sz - (1 << t_dw) + j : j;
            e = ssnap[t_sfx ? k % (1 << t_sw) : k];
            if (bmem[11'(t_dst + j)] != e) mism++;
        end
        chk(mism == 0, "R4", {tag, " byte mismatches"}, 32'(mism), 0);
        chk(bad_n == 0 && rd_n == (t_sz >> t_sw) && wr_n == (t_sz >> t_dw), "R5/R6",
            {tag, " beat sequence errors"}, 32'(bad_n), 0);
    endtask

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 2048; i++) bmem[i] = 8'($urandom);
        repeat (3) @(negedge clk);
        // R1 reset state
        rd_reg(A_STAT, v);  chk(v == 0, "R1", "status after reset", v, 0);
        chk(mem_req == 1'b0, "R1", "request after reset", {31'b0, mem_req}, 0);
        rd_reg(A_SCFG, v);  chk(v == 0, "R1", "config after reset", v, 0);
        rst_n = 1'b1;
        rd_reg(A_STAT, v);  chk(v == 0, "R1", "status out of reset", v, 0);

        // R2 register map and config field positions
        wr_reg(A_SCFG, 32'hFFFF_FFFF); rd_reg(A_SCFG, v);
        chk(v == 32'h0007_0103, "R2", "source config readback", v, 32'h0007_0103);
        wr_reg(A_DCFG, 32'h0003_0001); rd_reg(A_DCFG, v);
        chk(v == 32'h0003_0001, "R2", "dest config readback", v, 32'h0003_0001);
        wr_reg(A_SIZE, 32'hFFFF_FFFF); rd_reg(A_SIZE, v);
        chk(v == 32'h000F_FFFF, "R2", "size readback", v, 32'h000F_FFFF);
        wr_reg(A_DIR, 32'h3); rd_reg(A_DIR, v);
        chk(v == 32'h1, "R2", "direction readback", v, 1);
        wr_reg(A_DST, 32'h1234_5678); rd_reg(A_DST, v);
        chk(v == 32'h1234_5678, "R2", "dest address readback", v, 32'h1234_5678);
        rd_reg(A_CMD, v);  chk(v == 0, "R2", "command reads zero", v, 0);

        // R3 R4 R11: flash-read shape, 16-bit 16-beat in, 32-bit 16-beat out
        launch(64, 1024, 1, 2, 4, 4, 0, 0, 64, 1'b0);
        rd_reg(A_STAT, v);
        chk(v == ST_BUSY, "R3", "busy after start", v, ST_BUSY);
        chk(flash_write == 1'b0, "R11", "direction level on read", {31'b0, flash_write}, 0);
        finish("read page");

        // R4 R11: flash-write shape, widths reversed
        launch(200, 1100, 2, 1, 4, 4, 0, 0, 128, 1'b1);
        chk(flash_write == 1'b1, "R11", "direction level on write", {31'b0, flash_write}, 1);
        finish("write page");
        wr_reg(A_CMD, 32'h0004_0000);
        rd_reg(A_STAT, v); chk(v == 0, "R9", "done cleared", v, 0);

        // R6 final burst shortened: 16-bit 8-beat source, 20 bytes
        gnt_pct = 60;
        launch(8, 1300, 1, 2, 3, 0, 0, 0, 20, 1'b0);
        finish("short burst");

        // R5 fixed source and fixed destination, 8-bit beats
        launch(300, 1400, 2, 0, 2, 2, 1, 0, 24, 1'b0);
        finish("fixed source");
        launch(40, 1500, 0, 1, 4, 2, 0, 1, 30, 1'b0);
        finish("fixed dest");

        // R7 zero byte count
        launch(0, 1024, 1, 2, 4, 4, 0, 0, 0, 1'b0);
        rd_reg(A_STAT, v);
        chk(v == ST_DONE && hs_n == 0, "R7", "zero count done, no beats", v, ST_DONE);

        // R8 count not a multiple of the wider width, then an undefined width code
        launch(0, 1024, 1, 2, 4, 4, 0, 0, 6, 1'b0);
        rd_reg(A_STAT, v);
        chk(v == (ST_DONE | ST_ERR) && hs_n == 0, "R8", "bad count rejected", v, ST_DONE | ST_ERR);
        launch(0, 1024, 3, 2, 4, 4, 0, 0, 16, 1'b0);
        rd_reg(A_STAT, v);
        chk(v == (ST_DONE | ST_ERR) && hs_n == 0, "R8", "bad width rejected", v, ST_DONE | ST_ERR);

        // R8 bus error on the second source beat
        err_en = 1'b1; err_addr = 32'd132; gnt_pct = 100;
        launch(128, 1024, 2, 2, 2, 2, 0, 0, 32, 1'b0);
        wait_idle();
        rd_reg(A_STAT, v);
        chk(v == (ST_DONE | ST_ERR), "R8", "bus error status", v, ST_DONE | ST_ERR);
        repeat (10) @(negedge clk);
        chk(hs_n == 2 && mem_req == 1'b0, "R8", "beats after bus error", 32'(hs_n), 2);
        err_en = 1'b0;

        // R9 clear ordering
        wr_reg(A_CMD, 32'h0004_0000); rd_reg(A_STAT, v);
        chk(v == (ST_DONE | ST_ERR), "R9", "done clear blocked by error", v, ST_DONE | ST_ERR);
        wr_reg(A_CMD, 32'h0005_0000); rd_reg(A_STAT, v);
        chk(v == ST_DONE, "R9", "both bits clear error only", v, ST_DONE);
        wr_reg(A_CMD, 32'h0004_0000); rd_reg(A_STAT, v);
        chk(v == 0, "R9", "done clear after error clear", v, 0);

        // R10 restart and reprogramming while busy
        gnt_pct = 25;
        launch(400, 1600, 0, 2, 4, 3, 0, 0, 96, 1'b0);
        wr_reg(A_SRC, 32'd800);
        wr_reg(A_SCFG, 32'h0000_0102);
        wr_reg(A_CMD, 32'h1);
        finish("busy restart");
        repeat (20) @(negedge clk);
        chk(mem_req == 1'b0 && rd_n == 96, "R10", "no second transfer", 32'(rd_n), 96);

        // Seeded random transfers
        for (int i = 0; i < 24; i++) begin
            int sw, dw, mw;
            sw = $urandom % 3; dw = $urandom % 3; mw = (sw > dw) ? sw : dw;
            gnt_pct = 40 + ($urandom % 61);
            launch(($urandom % 128) << 2, 1024 + (($urandom % 128) << 2), sw, dw,
                   (($urandom % 4) == 0) ? 0 : 2 + ($urandom % 3),
                   (($urandom % 4) == 0) ? 0 : 2 + ($urandom % 3),
                   ($urandom % 5) == 0, ($urandom % 5) == 0,
                   (1 << mw) * (1 + ($urandom % 40)), 1'($urandom));
            finish($sformatf("random %0d", i));
        end

        summary();
        $finish;
    end

endmodule